// File: doc/BRIEF.md
# Integer ALU with Shifter, Multiplier and Condition Flags

This block is the purely combinational execute unit of a small 32-bit RISC core. Each cycle it receives an operation code and two operands. Operand A is the current value of the destination register. Operand B is either a second register or an immediate. The block returns a 32-bit result and a four-bit condition word.

The operations are add, subtract, compare, bit test, AND, OR, XOR, complement, the three shifts, rotate left, and 16x16 multiplies in unsigned and signed forms. Compare and bit test only produce flags. For them the block raises a flag output that tells the core to skip the register write.

Carry and overflow carry meaning for shifts as well as for arithmetic. Carry holds the last bit that left the word. Overflow reports that the sign bit changed. A decoder turns the operation code into a small set of strobes. The datapath then computes the operation those strobes select.

Top module: `coreAlu`

## Requirements
- R1: The condition word `flags` packs zero in bit 0, carry in bit 1, negative in bit 2 and overflow in bit 3. Zero is set exactly when `result` is 0, and negative equals `result[31]`, for every code. Codes 14 and 15 return 0 with carry and overflow clear.
- R2: Code 0 (add) returns A+B modulo 2^32. Carry is the carry out of bit 31. Overflow is set when both operands share a sign that the sum lacks; for example, 0x7FFFFFFF+1 sets overflow and 0xFFFFFFFF+1 gives 0 with carry set.
- R3: Code 1 (subtract) returns A-B. Carry is set when B exceeds A as unsigned numbers, so it acts as a borrow. Overflow is set on signed overflow; for example, 0-1 sets carry and 0x80000000-1 sets overflow.
- R4: Code 2 (compare) gives the flags of A-B, and code 3 (test) gives the flags of A AND B with carry and overflow clear. `noWrite` is 1 for codes 2 and 3 only.
- R5: Codes 4, 5, 6 and 7 return A AND B, A OR B, A XOR B and NOT A respectively, with carry and overflow clear.
- R6: Code 8 (logical left shift) shifts A left by B places. Carry is the last bit shifted out. Overflow is set when `result[31]` differs from `A[31]`.
- R7: Code 9 (logical right shift) shifts A right by B places, filling with zeros. Carry is the last bit shifted out. Overflow is set when the sign bit changes; for example, 0x80000000 shifted by 1 sets overflow, and 1 shifted by 1 gives 0 with carry set.
- R8: Code 10 (arithmetic right shift) shifts A right by B places, filling with `A[31]`. Carry is the last bit shifted out, and overflow is always clear; for example, 0xFFFFFFFF shifted by 32 stays 0xFFFFFFFF with carry set.
- R9: A shift by 0 returns A unchanged with carry and overflow clear. Any shift amount above 32 acts as 32, so 0xFFFFFFFF shifted right logically by 32 or more gives 0.
- R10: Code 11 (rotate left) rotates A left by B modulo 32 places, with carry and overflow clear.
- R11: Code 12 (unsigned multiply) returns the 32-bit product of the low 16 bits of A and B taken as unsigned numbers, with carry and overflow clear; for example, 0xFFFF*0xFFFF gives 0xFFFE0001.
- R12: Code 13 (signed multiply) sign-extends the low 16 bits of A and B and returns their 32-bit product, with carry and overflow clear; for example, 0x8001*0x7FFF gives 0xC000FFFF and 0x8000*0x8000 gives 0x40000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 4 | Operation code |
| opA | input | 32 | Destination register value |
| opB | input | 32 | Second register or immediate; shift amount for shifts |
| result | output | 32 | Computed value |
| flags | output | 4 | Condition word {V,N,C,Z} |
| noWrite | output | 1 | Result must not be written back (compare, test) |

## Verification
The shifter can raise carry and overflow together in one evaluation. A logical right shift by 1 of 0x80000001 pushes out a 1 and also clears the sign bit. A left shift by 1 of 0x80000000 does the same from the other end. The bench drives such operands on purpose and expects both bits set in the condition word at once. It also runs seeded random operands with shift amounts that cluster around 0, 31, 32 and beyond. Every response is compared against a bit-by-bit shift model written as a loop.

// File: rtl/coreAluPkg.sv
package coreAluPkg;
  localparam int DATA_W = 32;
  localparam int MUL_W  = 16;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,  OP_SUB = 4'd1,  OP_CMP = 4'd2,  OP_TST  = 4'd3,
    OP_AND  = 4'd4,  OP_OR  = 4'd5,  OP_XOR = 4'd6,  OP_NOT  = 4'd7,
    OP_LSL  = 4'd8,  OP_LSR = 4'd9,  OP_ASR = 4'd10, OP_ROL  = 4'd11,
    OP_MPYU = 4'd12, OP_MPYS = 4'd13, OP_RSV0 = 4'd14, OP_RSV1 = 4'd15
  } aluOp_e;

  typedef enum logic [2:0] {SEL_ZERO, SEL_ARITH, SEL_LOGIC, SEL_SHIFT, SEL_MUL} resSel_e;
  typedef enum logic [1:0] {LF_AND, LF_OR, LF_XOR, LF_NOT} logicFn_e;
  typedef enum logic [1:0] {SF_LSL, SF_LSR, SF_ASR, SF_ROL} shiftFn_e;

  typedef struct packed {
    resSel_e  resSel;
    logic     subtract;
    logicFn_e logicFn;
    shiftFn_e shiftFn;
    logic     mulSigned;
    logic     noWrite;
  } aluCtl_t;
endpackage

// File: rtl/coreAluCtl.sv
module coreAluCtl
  import coreAluPkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output aluCtl_t         ctl
);
  always_comb begin
    ctl = '{resSel: SEL_ZERO, subtract: 1'b0, logicFn: LF_AND,
            shiftFn: SF_LSL, mulSigned: 1'b0, noWrite: 1'b0};
    unique case (aluOp_e'(opSel))
      OP_ADD:  ctl.resSel = SEL_ARITH;
      OP_SUB:  begin ctl.resSel = SEL_ARITH; ctl.subtract = 1'b1; end
      OP_CMP:  begin ctl.resSel = SEL_ARITH; ctl.subtract = 1'b1; ctl.noWrite = 1'b1; end
      OP_TST:  begin ctl.resSel = SEL_LOGIC; ctl.logicFn = LF_AND; ctl.noWrite = 1'b1; end
      OP_AND:  begin ctl.resSel = SEL_LOGIC; ctl.logicFn = LF_AND; end
      OP_OR:   begin ctl.resSel = SEL_LOGIC; ctl.logicFn = LF_OR;  end
      OP_XOR:  begin ctl.resSel = SEL_LOGIC; ctl.logicFn = LF_XOR; end
      OP_NOT:  begin ctl.resSel = SEL_LOGIC; ctl.logicFn = LF_NOT; end
      OP_LSL:  begin ctl.resSel = SEL_SHIFT; ctl.shiftFn = SF_LSL; end
      OP_LSR:  begin ctl.resSel = SEL_SHIFT; ctl.shiftFn = SF_LSR; end
      OP_ASR:  begin ctl.resSel = SEL_SHIFT; ctl.shiftFn = SF_ASR; end
      OP_ROL:  begin ctl.resSel = SEL_SHIFT; ctl.shiftFn = SF_ROL; end
      OP_MPYU: ctl.resSel = SEL_MUL;
      OP_MPYS: begin ctl.resSel = SEL_MUL; ctl.mulSigned = 1'b1; end
      default: ctl.resSel = SEL_ZERO;
    endcase
  end
endmodule

// File: rtl/coreAluDp.sv
module coreAluDp
  import coreAluPkg::*;
#(
  parameter int DW = DATA_W,
  parameter int MW = MUL_W
) (
  input  aluCtl_t       ctl,
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] opB,
  output logic [DW-1:0] result,
  output logic [3:0]    flags
);
  localparam int AMT_W  = $clog2(DW) + 1;
  localparam int ROT_W  = AMT_W - 1;
  localparam int PROD_W = 2 * MW;

  // adder shared by add, subtract and compare
  logic [DW-1:0] addB, sumRes;
  logic [DW:0]   sumExt;
  logic          sumC, sumV;
  always_comb begin
    addB   = ctl.subtract ? ~opB : opB;
    sumExt = {1'b0, opA} + {1'b0, addB} + {{DW{1'b0}}, ctl.subtract};
    sumRes = sumExt[DW-1:0];
    sumC   = ctl.subtract ? ~sumExt[DW] : sumExt[DW];
    sumV   = (opA[DW-1] == addB[DW-1]) && (sumRes[DW-1] != opA[DW-1]);
  end

  // logic unit
  logic [DW-1:0] logRes;
  always_comb begin
    unique case (ctl.logicFn)
      LF_AND: logRes = opA & opB;
      LF_OR:  logRes = opA | opB;
      LF_XOR: logRes = opA ^ opB;
      default: logRes = ~opA;
    endcase
  end

  // shifter: amount clamped to DW, one guard bit catches the carry
  logic [AMT_W-1:0] shAmt;
  logic [ROT_W-1:0] rotAmt;
  logic [DW:0]      lslExt, lsrExt, asrExt;
  logic [2*DW-1:0]  rolWide;
  logic [DW-1:0]    shRes;
  logic             shC, shV;
  always_comb begin
    shAmt   = (opB >= DW) ? AMT_W'(DW) : opB[AMT_W-1:0];
    rotAmt  = opB[ROT_W-1:0];
    lslExt  = {1'b0, opA} << shAmt;
    lsrExt  = {opA, 1'b0} >> shAmt;
    asrExt  = $signed({opA, 1'b0}) >>> shAmt;
    rolWide = {opA, opA} << rotAmt;
    unique case (ctl.shiftFn)
      SF_LSL: begin shRes = lslExt[DW-1:0]; shC = lslExt[DW]; end
      SF_LSR: begin shRes = lsrExt[DW:1];   shC = lsrExt[0];  end
      SF_ASR: begin shRes = asrExt[DW:1];   shC = asrExt[0];  end
      default: begin shRes = rolWide[2*DW-1:DW]; shC = 1'b0; end
    endcase
    shV = (ctl.shiftFn != SF_ROL) && (shRes[DW-1] != opA[DW-1]);
  end

  // 16x16 multiplier, both signednesses
  logic [PROD_W-1:0]        prodU;
  logic signed [PROD_W-1:0] prodS;
  logic [DW-1:0]            mulRes;
  always_comb begin
    prodU  = opA[MW-1:0] * opB[MW-1:0];
    prodS  = $signed(opA[MW-1:0]) * $signed(opB[MW-1:0]);
    mulRes = ctl.mulSigned ? DW'(prodS) : DW'(prodU);
  end

  // result mux and condition word {V,N,C,Z}
  logic resC, resV;
  always_comb begin
    resC = 1'b0;
    resV = 1'b0;
    unique case (ctl.resSel)
      SEL_ARITH: begin result = sumRes; resC = sumC; resV = sumV; end
      SEL_LOGIC: result = logRes;
      SEL_SHIFT: begin result = shRes; resC = shC; resV = shV; end
      SEL_MUL:   result = mulRes;
      default:   result = '0;
    endcase
    flags = {resV, result[DW-1], resC, (result == '0)};
  end
endmodule

// File: rtl/coreAlu.sv
module coreAlu
  import coreAluPkg::*;
(
  input  logic [3:0]  opSel,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  output logic [31:0] result,
  output logic [3:0]  flags,
  output logic        noWrite
);
  aluCtl_t ctl;

  coreAluCtl ctl_i (.opSel(opSel), .ctl(ctl));

  coreAluDp #(.DW(DATA_W), .MW(MUL_W)) dp_i (
    .ctl(ctl), .opA(opA), .opB(opB), .result(result), .flags(flags)
  );

  assign noWrite = ctl.noWrite;
endmodule

// File: rtl/coreAluChk.sv
module coreAluChk
  import coreAluPkg::*;
(
  input logic [3:0]  opSel,
  input logic [31:0] opA,
  input logic [31:0] opB,
  input logic [31:0] result,
  input logic [3:0]  flags,
  input logic        noWrite
);
  always_comb begin
    // R1
    zero_flag_chk: assert (flags[0] == (result == 32'd0));
    // R4
    no_write_chk: assert (noWrite == (opSel == OP_CMP || opSel == OP_TST));
    if (opSel >= OP_AND && opSel <= OP_NOT) begin
      // R5
      logic_cv_chk: assert (flags[1] == 1'b0 && flags[3] == 1'b0);
    end
    if (opSel == OP_ASR) begin
      // R8
      asr_sign_chk: assert (result[31] == opA[31] && flags[3] == 1'b0);
    end
    if (opSel >= OP_LSL && opSel <= OP_ASR && opB == 32'd0) begin
      // R9
      zero_shift_chk: assert (result == opA && flags[1] == 1'b0);
    end
    if (opSel == OP_ROL) begin
      // R10
      rol_ones_chk: assert ($countones(result) == $countones(opA) && flags[1] == 1'b0);
    end
  end
endmodule

bind coreAlu coreAluChk chk_i (.*);

// File: tb/coreAlu_tb_top.sv
module coreAlu_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [3:0]  opSel;
  logic [31:0] opA, opB;
  logic [31:0] result;
  logic [3:0]  flags;
  logic        noWrite;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  coreAlu dut_i (.opSel(opSel), .opA(opA), .opB(opB),
                 .result(result), .flags(flags), .noWrite(noWrite));

  // reference model: {noWrite, V, N, C, Z, result}
  function automatic logic [36:0] model(input logic [3:0] op,
                                        input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r = 0;
    logic c = 0, v = 0, nw = 0;
    int n;
    longint unsigned wide;
    int sa, sb;
    case (op)
      0: begin wide = longint'(a) + longint'(b); r = wide[31:0]; c = wide[32];
               v = (a[31] == b[31]) && (r[31] != a[31]); end
      1, 2: begin r = a - b; c = (b > a); v = (a[31] != b[31]) && (r[31] != a[31]);
                  nw = (op == 2); end
      3: begin r = a & b; nw = 1; end
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7: r = ~a;
      8, 9, 10: begin
        n = (b > 32) ? 32 : int'(b);
        r = a;
        for (int i = 0; i < n; i++) begin
          if (op == 8) begin c = r[31]; r = {r[30:0], 1'b0}; end
          else if (op == 9) begin c = r[0]; r = {1'b0, r[31:1]}; end
          else begin c = r[0]; r = {r[31], r[31:1]}; end
        end
        v = (r[31] != a[31]);
      end
      11: begin r = a; for (int i = 0; i < int'(b % 32); i++) r = {r[30:0], r[31]}; end
      12: r = {16'd0, a[15:0]} * {16'd0, b[15:0]};
      13: begin sa = int'(signed'(a[15:0])); sb = int'(signed'(b[15:0])); r = sa * sb; end
      default: r = 0;
    endcase
    return {nw, v, r[31], c, (r == 0), r};
  endfunction

  task automatic check(input string req, input logic [3:0] op,
                       input logic [31:0] a, input logic [31:0] b);
    logic [36:0] exp;
    @(negedge clk);
    opSel = op; opA = a; opB = b;
    #2;
    exp = model(op, a, b);
    checks++;
    if ({noWrite, flags, result} !== exp) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h: got nw=%b flags=%b res=%h, expected nw=%b flags=%b res=%h",
               req, op, a, b, noWrite, flags, result, exp[36], exp[35:32], exp[31:0]);
    end
  endtask

  task automatic checkLit(input string req, input logic [3:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic [31:0] er, input logic [3:0] ef);
    @(negedge clk);
    opSel = op; opA = a; opB = b;
    #2;
    checks++;
    if (result !== er || flags !== ef) begin
      fails++;
      $display("FAIL %s op=%0d: got res=%h flags=%b, expected res=%h flags=%b",
               req, op, result, flags, er, ef);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0]  rop;
    logic [31:0] ra, rb;
    opSel = 0; opA = 0; opB = 0;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R1 quiescent inputs: add 0+0 gives Z only
    checkLit("R1", 4'd0, 0, 0, 32'd0, 4'b0001);
    checkLit("R1", 4'd14, 32'h1234, 32'h5678, 32'd0, 4'b0001);
    checkLit("R2", 4'd0, 32'h7FFFFFFF, 1, 32'h80000000, 4'b1100);
    checkLit("R2", 4'd0, 32'hFFFFFFFF, 1, 32'd0, 4'b0011);
    checkLit("R3", 4'd1, 32'h0, 1, 32'hFFFFFFFF, 4'b0110);
    checkLit("R3", 4'd1, 32'h80000000, 1, 32'h7FFFFFFF, 4'b1000);
    check("R4", 4'd2, 32'd5, 32'd5);
    check("R4", 4'd3, 32'hF0F0, 32'h0F0F);
    check("R5", 4'd7, 32'h0, 32'h0);
    check("R5", 4'd6, 32'hDEADBEEF, 32'hDEADBEEF);
    checkLit("R7", 4'd9, 32'd1, 1, 32'd0, 4'b0011);
    checkLit("R7", 4'd9, 32'd0, 1, 32'd0, 4'b0001);
    checkLit("R7", 4'd9, 32'h80000000, 1, 32'h40000000, 4'b1000);
    checkLit("R7", 4'd9, 32'h80000001, 1, 32'h40000000, 4'b1010);
    checkLit("R6", 4'd8, 32'h40000000, 1, 32'h80000000, 4'b1100);
    checkLit("R6", 4'd8, 32'h80000000, 1, 32'h0, 4'b1011);
    checkLit("R6", 4'd8, 32'h35, 8, 32'h3500, 4'b0000);
    checkLit("R8", 4'd10, 32'hFFFFFFFF, 32, 32'hFFFFFFFF, 4'b0110);
    checkLit("R8", 4'd10, 32'hFFFFFFFF, 1, 32'hFFFFFFFF, 4'b0110);
    checkLit("R9", 4'd9, 32'hFFFFFFFF, 0, 32'hFFFFFFFF, 4'b0100);
    checkLit("R9", 4'd9, 32'hFFFFFFFF, 32, 32'h0, 4'b1011);
    checkLit("R9", 4'd9, 32'hFFFFFFFF, 33, 32'h0, 4'b1011);
    check("R9", 4'd8, 32'h00000001, 32'hFFFFFFFF);
    check("R9", 4'd10, 32'h80000000, 32'd1000);
    check("R10", 4'd11, 32'h80000001, 32'd33);
    check("R10", 4'd11, 32'h12345678, 32'd0);
    checkLit("R11", 4'd12, 32'hABCDFFFF, 32'h0000FFFF, 32'hFFFE0001, 4'b0100);
    checkLit("R11", 4'd12, 32'd23171, 32'd23171, 32'd536895241, 4'b0000);
    checkLit("R12", 4'd13, 32'h8001, 32'h7FFF, 32'hC000FFFF, 4'b0100);
    checkLit("R12", 4'd13, 32'h8000, 32'h8000, 32'h40000000, 4'b0000);
    // seeded random mix, all requirements R1..R12 via the model
    for (int k = 0; k < 600; k++) begin
      rop = 4'($urandom_range(0, 15));
      ra  = $urandom;
      rb  = $urandom;
      if (rop >= 8 && rop <= 11) begin
        case ($urandom_range(0, 3))
          0: rb = 32'($urandom_range(0, 2));
          1: rb = 32'($urandom_range(30, 34));
          2: rb = 32'($urandom_range(0, 40));
          default: ;
        endcase
      end
      if ($urandom_range(0, 7) == 0) ra = 32'h80000000 | 32'($urandom_range(0, 1));
      check("R1 random", rop, ra, rb);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule